// File: doc/BRIEF.md
# Paired-Byte Word Write Bus Controller

This block sits between a processor core's table-access unit and an external word-organised memory on a multiplexed 16-bit address/data bus. It takes one request at a time. A request carries a byte pointer, a data byte and an operation kind, and the block runs one complete bus cycle for it. The cycle starts with an address phase. The word address is the byte pointer shifted right by one. Its low 16 bits go onto the shared bus while the address latch enable is high, and bits 19:16 go onto separate upper lines when the wide-address variant is built.

Write requests are combined in pairs. A write to an even byte address does not touch memory. It only parks the byte in a holding register, and the bus floats for the rest of that cycle. A write to an odd byte address then issues one real word write. The new byte goes on bus bits 15:8 and the parked byte on bits 7:0. Both byte-lane selects are active, and only the high write strobe is pulsed, framed by setup and hold phases. Read and opcode-fetch requests release the bus after the address phase, raise output enable and capture the 16-bit word at the end of the cycle. Every cycle ends with a one-clock done pulse.

Top module: `wordBusCtrl`

## Requirements
- R1: After reset the block is idle with `busy`, `done`, `ale`, `adOe`, `chipEn`, `outEn`, `wrHigh`, `upperSel`, `lowerSel` and `byteAddr` all low. The holding register is 0x00, so an odd write issued first puts 0x00 on bus bits 7:0.
- R2: A request accepted while idle (`startReq` high at a rising edge) begins an address phase of ADDR_CYC cycles. In that phase `ale` and `adOe` are high and `adOut` equals byte pointer bits 16:1. `upperAddr` equals pointer bits 20:17 when WIDE_ADDR is 1.
- R3: A write (`opKind` = 2'b00) with pointer bit 0 = 0 leaves `adOe` low after the address phase, never raises `wrHigh`, and stores the data byte in the holding register.
- R4: A write with pointer bit 0 = 1 drives `adOut` = {new data byte, holding register} for all SETUP_CYC+STRB_CYC+HOLD_CYC data-phase cycles. `wrHigh` is high only in the STRB_CYC cycles that follow the SETUP_CYC setup cycles, so the bus stays driven for HOLD_CYC cycles after the strobe drops.
- R5: `wrLow` is never asserted. `upperSel` and `lowerSel` are both high for every cycle of every bus operation.
- R6: `byteAddr` equals bit 0 of the accepted pointer throughout the bus cycle.
- R7: A read (2'b01) or fetch (2'b10 or 2'b11) leaves `adOe` low and holds `outEn` high from the end of the address phase to the end of the cycle. `rdWord` takes the value of `adIn` sampled at the last cycle's closing edge.
- R8: `busy` is high for exactly ADDR_CYC+SETUP_CYC+STRB_CYC+HOLD_CYC cycles, and `done` pulses high for one cycle right after. A `startReq` seen while busy is ignored.
- R9: Read and fetch cycles leave the holding register unchanged. An odd write always uses the byte from the most recent even write, even if reads came in between.
- R10: `chipEn` is high for every cycle of a bus operation and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request strobe, taken when idle |
| opKind | input | 2 | 00 write, 01 read, 10/11 fetch |
| bytePtr | input | PTR_W | Byte pointer |
| wrData | input | 8 | Write data byte |
| adIn | input | 16 | Bus value read back from memory |
| adOut | output | 16 | Bus value driven by the block |
| adOe | output | 1 | Bus output enable (low = tri-stated) |
| upperAddr | output | PTR_W-17 | Word address bits 19:16 |
| ale | output | 1 | Address latch enable |
| chipEn | output | 1 | Memory chip enable (active high) |
| outEn | output | 1 | Memory output enable (active high) |
| wrHigh | output | 1 | High write strobe (active high) |
| wrLow | output | 1 | Low write strobe, held inactive |
| upperSel | output | 1 | Upper byte-lane select |
| lowerSel | output | 1 | Lower byte-lane select |
| byteAddr | output | 1 | Pointer bit 0 |
| rdWord | output | 16 | Captured read/fetch word |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `adIn` is only meaningful while output enable is high and that `opKind`, `bytePtr` and `wrData` only matter at the edge where a request is taken. They do not assume that callers pair their writes. The bench therefore changes pointer and data only in the cycle where it raises `startReq`. It issues lone odd writes on purpose to exercise the stale-byte path. It also raises `startReq` during a running cycle with a different pointer to confirm that the accepted cycle is left alone.

// File: rtl/wordBusPkg.sv
package wordBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STRB,
    ST_HOLD
  } busState_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_FETCH = 2'b10,
    OP_FETCH2 = 2'b11
  } busOp_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;
    logic driveAddr;
    logic driveData;
    logic strobeWr;
    logic readEn;
    logic captureRd;
    logic loadHold;
    logic cycleActive;
  } busCtl_t;

endpackage

// File: rtl/wordBusCtl.sv
module wordBusCtl
  import wordBusPkg::*;
#(
  parameter int ADDR_CYC  = 2,
  parameter int SETUP_CYC = 1,
  parameter int STRB_CYC  = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic [1:0] opKind,
  input  logic    oddQ,
  output busCtl_t ctl,
  output logic    busy,
  output logic    done
);

  localparam int MAX_AB = (ADDR_CYC > SETUP_CYC) ? ADDR_CYC : SETUP_CYC;
  localparam int MAX_CD = (STRB_CYC > HOLD_CYC) ? STRB_CYC : HOLD_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C) + 1;

  busState_t  state;
  logic [CNT_W-1:0] cnt;
  logic       isWr;
  logic       cntZero;
  logic       inData;
  logic       lastHold;

  assign cntZero  = (cnt == '0);
  assign inData   = (state == ST_SETUP) || (state == ST_STRB) || (state == ST_HOLD);
  assign lastHold = (state == ST_HOLD) && cntZero;

  always_comb begin
    ctl             = '0;
    ctl.latchReq    = (state == ST_IDLE) && startReq;
    ctl.driveAddr   = (state == ST_ADDR);
    ctl.driveData   = inData && isWr && oddQ;
    ctl.strobeWr    = (state == ST_STRB) && isWr && oddQ;
    ctl.readEn      = inData && !isWr;
    ctl.captureRd   = lastHold && !isWr;
    ctl.loadHold    = lastHold && isWr && !oddQ;
    ctl.cycleActive = (state != ST_IDLE);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (startReq) begin
          state <= ST_ADDR;
          cnt   <= CNT_W'(ADDR_CYC - 1);
          isWr  <= (opKind == OP_WRITE);
        end
        ST_ADDR: if (cntZero) begin
          state <= ST_SETUP;
          cnt   <= CNT_W'(SETUP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_SETUP: if (cntZero) begin
          state <= ST_STRB;
          cnt   <= CNT_W'(STRB_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_STRB: if (cntZero) begin
          state <= ST_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cntZero) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_STRB_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeWr) |-> $past(ctl.driveData)); // R4
  AST_STRB_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.strobeWr) |-> ctl.driveData); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

// File: rtl/wordBusDp.sv
module wordBusDp
  import wordBusPkg::*;
#(
  parameter int PTR_W     = 21,
  parameter bit WIDE_ADDR = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  busCtl_t            ctl,
  input  logic [PTR_W-1:0]   bytePtr,
  input  logic [7:0]         wrData,
  input  logic [15:0]        adIn,
  output logic [15:0]        adOut,
  output logic               adOe,
  output logic [PTR_W-18:0]  upperAddr,
  output logic               byteAddr,
  output logic               oddQ,
  output logic               wrLow,
  output logic [15:0]        rdWord
);

  localparam int WADDR_W = PTR_W - 1;
  localparam int UPPER_W = WADDR_W - 16;

  logic [PTR_W-1:0]   ptrQ;
  logic [7:0]         dataQ;
  logic [7:0]         holdReg;
  logic [WADDR_W-1:0] wordAddr;

  assign wordAddr = ptrQ[PTR_W-1:1];
  assign oddQ     = ptrQ[0];
  assign byteAddr = ptrQ[0];
  assign wrLow    = 1'b0;
  assign adOe     = ctl.driveAddr || ctl.driveData;
  assign adOut    = ctl.driveAddr ? wordAddr[15:0] : {dataQ, holdReg};

  generate
    if (WIDE_ADDR) begin : gWide
      assign upperAddr = wordAddr[WADDR_W-1:16];
    end else begin : gNarrow
      assign upperAddr = {UPPER_W{1'b0}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      dataQ   <= 8'h00;
      holdReg <= 8'h00;
      rdWord  <= 16'h0000;
    end else begin
      if (ctl.latchReq) begin
        ptrQ  <= bytePtr;
        dataQ <= wrData;
      end
      if (ctl.loadHold)  holdReg <= dataQ;
      if (ctl.captureRd) rdWord  <= adIn;
    end
  end

  AST_HOLD_READ_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureRd |=> $stable(holdReg)); // R9
  AST_DATA_ODD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.driveData |-> oddQ); // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readEn |-> !adOe); // R7

endmodule

// File: rtl/wordBusCtrl.sv
module wordBusCtrl
  import wordBusPkg::*;
#(
  parameter int PTR_W     = 21,
  parameter bit WIDE_ADDR = 1'b1,
  parameter int ADDR_CYC  = 2,
  parameter int SETUP_CYC = 1,
  parameter int STRB_CYC  = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        opKind,
  input  logic [PTR_W-1:0]  bytePtr,
  input  logic [7:0]        wrData,
  input  logic [15:0]       adIn,
  output logic [15:0]       adOut,
  output logic              adOe,
  output logic [PTR_W-18:0] upperAddr,
  output logic              ale,
  output logic              chipEn,
  output logic              outEn,
  output logic              wrHigh,
  output logic              wrLow,
  output logic              upperSel,
  output logic              lowerSel,
  output logic              byteAddr,
  output logic [15:0]       rdWord,
  output logic              busy,
  output logic              done
);

  busCtl_t ctl;
  logic    oddQ;

  wordBusCtl #(
    .ADDR_CYC (ADDR_CYC),
    .SETUP_CYC(SETUP_CYC),
    .STRB_CYC (STRB_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .opKind  (opKind),
    .oddQ    (oddQ),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  wordBusDp #(
    .PTR_W    (PTR_W),
    .WIDE_ADDR(WIDE_ADDR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bytePtr  (bytePtr),
    .wrData   (wrData),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .upperAddr(upperAddr),
    .byteAddr (byteAddr),
    .oddQ     (oddQ),
    .wrLow    (wrLow),
    .rdWord   (rdWord)
  );

  assign ale      = ctl.driveAddr;
  assign outEn    = ctl.readEn;
  assign wrHigh   = ctl.strobeWr;
  assign chipEn   = ctl.cycleActive;
  assign upperSel = ctl.cycleActive;
  assign lowerSel = ctl.cycleActive;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !(outEn && adOe)); // R7
  AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> adOe); // R2
  AST_WR_ODD: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |-> (byteAddr && adOe && chipEn)); // R4
  AST_WR_NOT_ALE: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |-> !ale); // R4

endmodule

// File: tb/wordBusCtrl_tb_top.sv
module wordBusCtrl_tb_top;

  localparam int PTR_W = 21;
  localparam int ACYC  = 2;
  localparam int SCYC  = 1;
  localparam int WCYC  = 2;
  localparam int HCYC  = 1;
  localparam int TOTAL = ACYC + SCYC + WCYC + HCYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] opKind = 2'b00;
  logic [PTR_W-1:0] bytePtr = '0;
  logic [7:0] wrData = 8'h00;
  logic [15:0] adIn = 16'h0000;
  logic [15:0] adOut;
  logic adOe, ale, chipEn, outEn, wrHigh, wrLow, upperSel, lowerSel, byteAddr, busy, done;
  logic [3:0] upperAddr;
  logic [15:0] rdWord;

  int checks = 0;
  int failures = 0;
  logic [7:0] holdModel = 8'h00;
  logic [15:0] rdModel = 16'h0000;

  always #4 clk = ~clk;

  wordBusCtrl #(
    .PTR_W(PTR_W), .WIDE_ADDR(1'b1),
    .ADDR_CYC(ACYC), .SETUP_CYC(SCYC), .STRB_CYC(WCYC), .HOLD_CYC(HCYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opKind(opKind),
    .bytePtr(bytePtr), .wrData(wrData), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .upperAddr(upperAddr), .ale(ale), .chipEn(chipEn),
    .outEn(outEn), .wrHigh(wrHigh), .wrLow(wrLow), .upperSel(upperSel),
    .lowerSel(lowerSel), .byteAddr(byteAddr), .rdWord(rdWord),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus operation, every cycle compared against the requirement timing
  task automatic runOp(input logic [1:0] op, input logic [PTR_W-1:0] ptr,
                       input logic [7:0] data, input logic [15:0] busIn,
                       input bit probeBusy);
    bit isWr = (op == 2'b00);
    bit odd  = ptr[0];
    @(negedge clk);
    opKind = op; bytePtr = ptr; wrData = data; adIn = busIn; startReq = 1'b1;
    for (int i = 0; i < TOTAL; i++) begin
      bit inAddr = (i < ACYC);
      bit inStrb = (i >= ACYC + SCYC) && (i < ACYC + SCYC + WCYC);
      @(negedge clk);
      if (i == 0) startReq = 1'b0;
      if (probeBusy && i == 1) begin
        startReq = 1'b1; bytePtr = ptr ^ 21'h1F0F1; wrData = ~data;
      end
      if (probeBusy && i == 2) startReq = 1'b0;
      chk("R2 ale", ale, inAddr);
      chk("R3/R4 adOe", adOe, inAddr || (isWr && odd));
      if (inAddr) begin
        chk("R2 adOut address", adOut, ptr[16:1]);
        chk("R2 upperAddr", upperAddr, ptr[20:17]);
      end else if (isWr && odd) begin
        chk("R4 adOut data", adOut, {data, holdModel});
      end
      chk("R4 wrHigh", wrHigh, isWr && odd && inStrb);
      chk("R5 wrLow", wrLow, 1'b0);
      chk("R5 lane selects", {upperSel, lowerSel}, 2'b11);
      chk("R6 byteAddr", byteAddr, odd);
      chk("R7 outEn", outEn, !isWr && !inAddr);
      chk("R10 chipEn", chipEn, 1'b1);
      chk("R8 busy", busy, 1'b1);
      chk("R8 done early", done, 1'b0);
    end
    if (isWr && !odd) holdModel = data;
    if (!isWr) rdModel = busIn;
    @(negedge clk);
    chk("R8 done pulse", done, 1'b1);
    chk("R8 busy end", busy, 1'b0);
    chk("R10 chipEn idle", chipEn, 1'b0);
    chk("R7 rdWord", rdWord, rdModel);
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
    chk("R8 no extra cycle", busy, 1'b0);
  endtask

  task automatic testReset();
    chk("R1 idle busy", busy, 1'b0);
    chk("R1 idle done", done, 1'b0);
    chk("R1 idle strobes", {ale, adOe, chipEn, outEn, wrHigh, upperSel, lowerSel, byteAddr}, 8'h00);
  endtask

  task automatic testLoneOddAfterReset();
    runOp(2'b00, 21'h00_2A41, 8'h9C, 16'h0, 1'b0); // R1 low byte 0x00
  endtask

  task automatic testPairedWrite();
    runOp(2'b00, 21'h1_1234, 8'hA5, 16'h0, 1'b0); // R3
    runOp(2'b00, 21'h1_1235, 8'h5A, 16'h0, 1'b0); // R4
  endtask

  task automatic testReadKeepsHold();
    runOp(2'b00, 21'h0_0F00, 8'h3C, 16'h0, 1'b0);     // R3
    runOp(2'b01, 21'h1_8001, 8'hEE, 16'hBEEF, 1'b0);  // R7
    runOp(2'b10, 21'h0_4446, 8'h11, 16'h1357, 1'b0);  // R7 fetch
    runOp(2'b11, 21'h1_FFFF, 8'h22, 16'hC0DE, 1'b0);  // R7 fetch alias
    runOp(2'b00, 21'h0_0F01, 8'hC3, 16'h0, 1'b0);     // R9 low byte 0x3C
    runOp(2'b00, 21'h0_7777, 8'h81, 16'h0, 1'b0);     // R9 stale byte again
  endtask

  task automatic testBusyIgnore();
    runOp(2'b00, 21'h0_5554, 8'h66, 16'h0, 1'b1);     // R8
    runOp(2'b00, 21'h0_5555, 8'h77, 16'h0, 1'b1);     // R8
    runOp(2'b01, 21'h1_0002, 8'h00, 16'hA55A, 1'b1);  // R8
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testLoneOddAfterReset();
        testPairedWrite();
        testReadKeepsHold();
        testBusyIgnore();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule